// File: doc/BRIEF.md
# Multi-Cycle Memory Read Sequencer

This block sits between a processor core and a slow external memory. The memory cannot answer in the same cycle it is addressed, so every read is stretched over a fixed series of bus cycles. First the address goes out on its own. Then the read strobe is raised. One mandatory wait cycle follows. Last comes a completion cycle in which the captured word is handed back to the core.

When the memory is still not ready at the end of the mandatory wait, the sequencer inserts extra wait states, one per cycle. During these it keeps the strobe and the address steady and starts no other bus activity. It gives up after a configurable number of extra wait states and reports an error. The core issues a request with an address while the sequencer is idle. It then waits for the one-cycle completion pulse and reads the captured word.

Top module: `mem_read_seq`

## Requirements
- R1: A request (`req_i` high at a clock edge) is accepted only while `busy_o` is low; `busy_o` is high from the cycle after acceptance through the completion cycle, and the read strobe is never high while `busy_o` is low.
- R2: In the first cycle after acceptance, `mem_addr_o` carries the requested address and `mem_rd_o` is low.
- R3: In the second cycle `mem_rd_o` rises while `mem_addr_o` keeps the same value.
- R4: The third cycle is a mandatory wait cycle with `mem_rd_o` high whatever `mem_ready_i` does; `mem_ready_i` is first sampled at the end of this cycle.
- R5: Each time `mem_ready_i` is sampled low, one extra wait state is added with `mem_rd_o` high and the address held, so a read that needs k extra wait states completes in cycle 4+k after acceptance.
- R6: `mem_data_i` is captured at the clock edge that ends the last strobe cycle, and it appears on `rdata_o` in the completion cycle. It then holds until the next successful read.
- R7: In the completion cycle `done_o` is high for exactly one cycle, `mem_rd_o` is low, and `mem_addr_o` still holds the address. In the next cycle the block is idle and `mem_addr_o` is zero.
- R8: If `mem_ready_i` is still low after MAX_WAIT extra wait states, the read completes in cycle 4+MAX_WAIT with `err_o` high together with `done_o`, and `rdata_o` keeps its previous value; `err_o` is low on every successful completion.
- R9: A request raised while a read is in progress is ignored: the address, the strobe timing and the result of the current read are unaffected, and no second read follows.
- R10: A synchronous reset returns the block to idle with `mem_rd_o` low, `mem_addr_o` zero, `busy_o`, `done_o` and `err_o` low, and `rdata_o` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Read request from the core |
| req_addr_i | input | ADDR_W | Address of the requested word |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Wait-state limit reached, qualified by done_o |
| rdata_o | output | DATA_W | Captured read data |
| mem_addr_o | output | ADDR_W | Address bus to memory |
| mem_rd_o | output | 1 | Read strobe to memory, active high |
| mem_data_i | input | DATA_W | Data bus from memory |
| mem_ready_i | input | 1 | Memory has valid data |

## Verification
The hardest case to reach from the ports is the wait-state limit. It only occurs when the memory stays not-ready through the mandatory wait and then through every one of the MAX_WAIT extra cycles. The bench's behavioural memory raises ready only after a chosen number of strobe cycles. The random latency is drawn from a range that runs past MAX_WAIT, and directed reads sit exactly at MAX_WAIT and at MAX_WAIT+1. These reach both the last successful read and the first aborted one. Requests made in the middle of a read, and a reset in the middle of a read, are forced with directed stimulus.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_STRB,
        S_WAIT,
        S_XWAIT,
        S_FIN
    } seq_state_e;

    typedef struct packed {
        logic load_addr;
        logic clr_addr;
        logic capture;
        logic cnt_inc;
        logic cnt_clr;
        logic rd;
        logic busy;
        logic done;
    } seq_ctrl_t;

    function automatic logic strobe_of(input seq_state_e s);
        return (s == S_STRB) || (s == S_WAIT) || (s == S_XWAIT);
    endfunction

endpackage

// File: rtl/mrs_fsm.sv
module mrs_fsm
    import mrs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      ready,
    input  logic      wait_full,
    output seq_ctrl_t ctrl,
    output logic      err
);
    seq_state_e st, nxt;
    logic       abort;
    logic       err_q;

    always_comb begin
        nxt   = st;
        ctrl  = '0;
        abort = 1'b0;
        ctrl.rd   = strobe_of(st);
        ctrl.busy = (st != S_IDLE);
        ctrl.done = (st == S_FIN);
        case (st)
            S_IDLE: begin
                ctrl.cnt_clr = 1'b1;
                if (req) begin
                    nxt            = S_ADDR;
                    ctrl.load_addr = 1'b1;
                end
            end
            S_ADDR:  nxt = S_STRB;
            S_STRB:  nxt = S_WAIT;
            S_WAIT: begin
                if (ready) begin
                    nxt          = S_FIN;
                    ctrl.capture = 1'b1;
                end else begin
                    nxt          = S_XWAIT;
                    ctrl.cnt_inc = 1'b1;
                end
            end
            S_XWAIT: begin
                if (ready) begin
                    nxt          = S_FIN;
                    ctrl.capture = 1'b1;
                end else if (wait_full) begin
                    nxt   = S_FIN;
                    abort = 1'b1;
                end else begin
                    ctrl.cnt_inc = 1'b1;
                end
            end
            S_FIN: begin
                nxt           = S_IDLE;
                ctrl.clr_addr = 1'b1;
                ctrl.cnt_clr  = 1'b1;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            err_q <= 1'b0;
        end else begin
            st    <= nxt;
            err_q <= abort;
        end
    end

    assign err = err_q;

    // R8: an error is reported only in a completion cycle
    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (st == S_FIN));

endmodule

// File: rtl/mrs_waitcnt.sv
module mrs_waitcnt #(
    parameter int MAX_WAIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic full
);
    localparam int CW = $clog2(MAX_WAIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CW'(MAX_WAIT));

    // R8: the extra wait-state count never passes the limit
    assert_cnt_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAX_WAIT));

endmodule

// File: rtl/mrs_datapath.sv
module mrs_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_addr,
    input  logic              clr_addr,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst || clr_addr) begin
            addr_q <= '0;
        end else if (load_addr) begin
            addr_q <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= data_in;
        end
    end

    assign addr_out = addr_q;
    assign rdata    = rdata_q;

    // R6: the result register changes only on a capture
    assert_rdata_held_R6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(rdata_q));

endmodule

// File: rtl/mem_read_seq.sv
module mem_read_seq
    import mrs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int MAX_WAIT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic              mem_ready_i
);
    seq_ctrl_t ctrl;
    logic      wait_full;
    logic      err;

    mrs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req_i),
        .ready     (mem_ready_i),
        .wait_full (wait_full),
        .ctrl      (ctrl),
        .err       (err)
    );

    mrs_waitcnt #(.MAX_WAIT(MAX_WAIT)) u_waitcnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctrl.cnt_clr),
        .inc  (ctrl.cnt_inc),
        .full (wait_full)
    );

    mrs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load_addr (ctrl.load_addr),
        .clr_addr  (ctrl.clr_addr),
        .capture   (ctrl.capture),
        .addr_in   (req_addr_i),
        .data_in   (mem_data_i),
        .addr_out  (mem_addr_o),
        .rdata     (rdata_o)
    );

    assign busy_o   = ctrl.busy;
    assign done_o   = ctrl.done;
    assign err_o    = err;
    assign mem_rd_o = ctrl.rd;

    // R1: no strobe while idle
    assert_no_strobe_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_rd_o);

    // R3: the strobe rises on an address that is already stable
    assert_addr_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_o) |-> $stable(mem_addr_o) && busy_o);

    // R7: completion comes right after a strobe cycle, with the strobe low
    assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_rd_o && $past(mem_rd_o) && $stable(mem_addr_o));

    // R7: completion is a single-cycle pulse followed by idle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    // R10: reset drives the bus to its quiet state
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> !mem_rd_o && (mem_addr_o == '0) && !busy_o);

endmodule

// File: tb/test_mem_read_seq.sv
`timescale 1ns/1ps
module test_mem_read_seq;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int MAXW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          req;
    logic [AW-1:0] req_addr;
    logic          busy, done, err, mem_rd, mem_ready;
    logic [DW-1:0] rdata, mem_data;
    logic [AW-1:0] mem_addr;

    int lat;
    int rd_cnt;
    int checks = 0;
    int errors = 0;
    logic [DW-1:0] last_data;

    always #2 clk = ~clk;

    mem_read_seq #(.ADDR_W(AW), .DATA_W(DW), .MAX_WAIT(MAXW)) i_mem_read_seq (
        .clk(clk), .rst(rst), .req_i(req), .req_addr_i(req_addr),
        .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_data_i(mem_data), .mem_ready_i(mem_ready)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (a * 16'h9E37) ^ 16'h1F2D;
    endfunction

    function automatic int exp_done_cycle(input int l);
        return (l <= MAXW) ? 4 + l : 4 + MAXW;
    endfunction

    // behavioural memory: ready after (1 + lat) full strobe cycles
    always_ff @(posedge clk) rd_cnt <= mem_rd ? rd_cnt + 1 : 0;
    assign mem_ready = mem_rd && (rd_cnt >= 1 + lat);
    assign mem_data  = mem_rd ? mem_word(mem_addr) : '0;

    task automatic check(input bit ok, input string req_tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int l, input bit poke);
        int  n;
        int  exp_n;
        bit  proto_ok;
        bit  busy_ok;
        bit  seen_done;
        exp_n    = exp_done_cycle(l);
        proto_ok = 1'b1;
        busy_ok  = 1'b1;
        seen_done = 1'b0;
        lat = l;
        @(negedge clk);
        req = 1'b1;
        req_addr = a;
        n = 0;
        while (!seen_done && n < MAXW + 10) begin
            @(negedge clk);
            n++;
            req = 1'b0;
            if (poke && n == 2) begin
                req = 1'b1;
                req_addr = ~a;
            end
            if (!busy) busy_ok = 1'b0;
            if (n == 1) begin
                check(mem_addr == a && !mem_rd, "R2", "addr phase", {mem_addr, 7'b0, mem_rd}, {a, 8'b0});
            end else if (n == 2) begin
                check(mem_addr == a && mem_rd, "R3", "strobe phase", {mem_addr, 7'b0, mem_rd}, {a, 8'h01});
            end else if (n == 3) begin
                check(mem_rd && !done, "R4", "mandatory wait", mem_rd, 1);
            end else if (!done) begin
                if (!(mem_rd && mem_addr == a)) proto_ok = 1'b0;
            end
            if (done) seen_done = 1'b1;
        end
        req = 1'b0;
        check(proto_ok, "R5", "extra wait states hold strobe/addr", proto_ok, 1);
        check(busy_ok, "R1", "busy through read", busy_ok, 1);
        check(n == exp_n, "R5", "completion cycle", n, exp_n);
        check(!mem_rd && mem_addr == a, "R7", "bus in completion cycle", {mem_addr, 7'b0, mem_rd}, {a, 8'b0});
        if (l <= MAXW) begin
            last_data = mem_word(a);
            check(!err, "R8", "no error on success", err, 0);
            check(rdata == last_data, "R6", "captured data", rdata, last_data);
        end else begin
            check(err, "R8", "error on limit", err, 1);
            check(rdata == last_data, "R8", "data kept on error", rdata, last_data);
        end
        @(negedge clk);
        check(!done && !busy && mem_addr == '0, "R7", "idle after completion",
              {done, busy, mem_addr}, 0);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                check(!busy && !mem_rd, "R9", "no read from ignored request", {busy, mem_rd}, 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req = 1'b0;
        req_addr = '0;
        lat = 0;
        last_data = '0;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        check(!busy && !mem_rd && mem_addr == '0 && rdata == '0 && !done && !err,
              "R10", "reset state", {busy, mem_rd, done, err, rdata}, 0);
        rst = 1'b0;

        do_read(16'h1234, 0, 1'b0);
        do_read(16'hFFFF, 1, 1'b0);
        do_read(16'h0000, MAXW, 1'b0);
        do_read(16'hBEEF, MAXW + 1, 1'b0);
        do_read(16'h00A5, 2, 1'b1);

        for (int i = 0; i < 40; i++) begin
            do_read(AW'($urandom), int'($urandom_range(0, MAXW + 2)), i % 7 == 3);
            if (i % 5 == 0) repeat (2) @(negedge clk);
        end

        // R10: reset in the middle of a read
        lat = 3;
        @(negedge clk);
        req = 1'b1;
        req_addr = 16'h5A5A;
        repeat (3) @(negedge clk);
        req = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!mem_rd && mem_addr == '0 && !busy && !done && rdata == '0,
              "R10", "reset mid-read", {mem_rd, busy, done, mem_addr}, 0);
        rst = 1'b0;
        last_data = '0;
        do_read(16'h0F0F, 0, 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule